// File: doc/BRIEF.md
# Multi-channel TDM serial output multiplexer

This block is a time-division multiplexed transmitter. Up to sixteen logical channels share one serial data pin. A frame of 64, 128, 192 or 256 bit periods starts on each rising edge of a frame-sync input. Every channel owns a host-writable 16-bit holding register and a private 16-bit shift register, so the two form a double buffer. A channel drives the pin only while the frame position counter sits inside its slot. The slot begins at a programmable position from 0 to 255 and is 8, 4, 2 or 1 bits wide.

A channel's 16-bit word is spread over 2, 4, 8 or 16 frames, set by the channel's sample-length code. The shift register reloads from the holding register at the end of that period, so software can write the next word while the current one is still going out. The block is clocked by the bit clock. Host writes are synchronous to that clock. The serial bit changes just after a rising edge, so a receiver can capture it on the falling edge.

Top module: `tdm_serial_mux`

## Requirements
- R1: After reset, and from any (re)initialisation until the next rising frame sync, `sdo` is 0.
- R2: The control register (address 26) holds the frame-size code f in bits 1:0. The frame is 64*(f+1) bit periods long. The position counter returns to 0 after the last position, even when no frame sync arrives.
- R3: Each rising edge of `frame_sync`, sampled on `clk`, restarts the frame. Position 0 is driven in the cycle after that edge, even if the previous frame was not complete.
- R4: At the first rising frame sync after initialisation, all sixteen shift registers load from their holding registers together.
- R5: Sample-length register 24+j carries the 2-bit code c of channel 8j+i in bits 2i+1:2i. After the common load, a channel reloads at each later rising frame sync whose frame count since that load is a multiple of 2<<c frames.
- R6: In each frame a channel drives 16>>(c+1) consecutive bits, starting at its start position. Its word goes out LSB first, and each frame continues where the previous one stopped. Once all 16 bits are sent, the remaining slot bits are 0.
- R7: Holding registers sit at addresses 0..15, one per channel. Start register 16+k holds channel 2k's start position in bits 7:0 and channel 2k+1's in bits 15:8.
- R8: Where slots overlap, the lowest-numbered active channel drives `sdo`.
- R9: Positions outside every active slot drive `sdo` to 0.
- R10: A write to the control register reinitialises the frame logic. `sdo` is 0 from the next cycle until the next rising frame sync, which then loads all channels as in R4.
- R11: A holding-register write does not alter the word being shifted. The new value is taken only at that channel's next load.
- R12: Only slot positions below the frame length are sent. A slot that starts at or beyond the frame length never drives `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state and host writes are on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 5 | Register address (0..15 data, 16..23 start, 24..25 length, 26 control) |
| wr_data | input | 16 | Host write data |
| frame_sync | input | 1 | Frame sync; its rising edge starts a frame |
| sdo | output | 1 | Serial data output |

## Verification
The stimulus first uses disjoint eight-bit slots with a uniform sample length. This separates the all-channel load and LSB-first ordering from any priority effect. Mixed sample-length codes run over sixteen or more frames while holding registers are rewritten mid-frame. This separates correct per-channel reload periods and double buffering from early or late reloads. Deliberately overlapping slots, start positions past the frame end, and a slot crossing the frame boundary expose priority and truncation errors. Frame syncs that arrive earlier or later than the programmed frame length separate restart-on-sync from the counter's own wrap.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned TDM_NUM_CH     = 16;
  localparam int unsigned TDM_DATA_W     = 16;
  localparam int unsigned TDM_POS_W      = 8;
  localparam int unsigned TDM_CODE_W     = 2;
  localparam int unsigned TDM_FSZ_W      = 2;
  localparam int unsigned TDM_FRAME_UNIT = 64;
  localparam int unsigned TDM_CNT_W      = 4;
  localparam int unsigned TDM_ADDR_W     = 5;
endpackage

// File: rtl/tdm_host_regs.sv
module tdm_host_regs
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = TDM_NUM_CH,
  parameter int unsigned DATA_W = TDM_DATA_W,
  parameter int unsigned POS_W  = TDM_POS_W,
  parameter int unsigned CODE_W = TDM_CODE_W,
  parameter int unsigned FSZ_W  = TDM_FSZ_W,
  parameter int unsigned AW     = TDM_ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][DATA_W-1:0]  hold_o,
  output logic [NUM_CH-1:0][POS_W-1:0]   start_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
  output logic [FSZ_W-1:0]               fsz_o,
  output logic                           init_o
);
  localparam int unsigned STARTS_PER_REG = DATA_W / POS_W;
  localparam int unsigned CODES_PER_REG  = DATA_W / CODE_W;
  localparam int unsigned START_BASE     = NUM_CH;
  localparam int unsigned LEN_BASE       = START_BASE + NUM_CH / STARTS_PER_REG;
  localparam int unsigned CTRL_ADDR      = LEN_BASE + NUM_CH / CODES_PER_REG;

  logic ctrl_we;
  logic [FSZ_W-1:0] fsz_q;

  assign ctrl_we = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign init_o  = ctrl_we;
  assign fsz_o   = fsz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fsz_q <= '0;
    else if (ctrl_we) fsz_q <= wr_data[FSZ_W-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned SREG  = START_BASE + ch / STARTS_PER_REG;
    localparam int unsigned SLANE = ch % STARTS_PER_REG;
    localparam int unsigned LREG  = LEN_BASE + ch / CODES_PER_REG;
    localparam int unsigned LLANE = ch % CODES_PER_REG;

    logic hold_we, start_we, code_we;
    logic [DATA_W-1:0] hold_q;
    logic [POS_W-1:0]  start_q;
    logic [CODE_W-1:0] code_q;

    assign hold_we  = wr_en && (wr_addr == AW'(ch));
    assign start_we = wr_en && (wr_addr == AW'(SREG));
    assign code_we  = wr_en && (wr_addr == AW'(LREG));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q  <= '0;
        start_q <= '0;
        code_q  <= '0;
      end else begin
        if (hold_we)  hold_q  <= wr_data;
        if (start_we) start_q <= wr_data[SLANE*POS_W +: POS_W];
        if (code_we)  code_q  <= wr_data[LLANE*CODE_W +: CODE_W];
      end
    end

    assign hold_o[ch]  = hold_q;
    assign start_o[ch] = start_q;
    assign code_o[ch]  = code_q;
  end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_pkg::*;
#(
  parameter int unsigned POS_W      = TDM_POS_W,
  parameter int unsigned FSZ_W      = TDM_FSZ_W,
  parameter int unsigned FRAME_UNIT = TDM_FRAME_UNIT,
  parameter int unsigned CNT_W      = TDM_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              init,
  input  logic [FSZ_W-1:0]  fsz,
  output logic [POS_W-1:0]  pos,
  output logic              running,
  output logic              fs_rise,
  output logic              load_all,
  output logic              reload_tick,
  output logic [CNT_W-1:0]  fcnt_inc
);
  localparam int unsigned LAST_W = POS_W + 1;

  logic             fs_q;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic [LAST_W-1:0] frame_last;

  assign frame_last = LAST_W'((32'(fsz) + 32'd1) * FRAME_UNIT - 32'd1);
  assign fs_rise    = frame_sync & ~fs_q;

  always_comb begin
    pos_d  = pos_q;
    run_d  = run_q;
    fcnt_d = fcnt_q;
    if (init) begin
      run_d = 1'b0;
    end else if (fs_rise) begin
      run_d  = 1'b1;
      pos_d  = '0;
      fcnt_d = run_q ? fcnt_q + 1'b1 : '0;
    end else if (run_q) begin
      pos_d = ({1'b0, pos_q} == frame_last) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      pos_q  <= '0;
      run_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      fs_q   <= frame_sync;
      pos_q  <= pos_d;
      run_q  <= run_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign pos         = pos_q;
  assign running     = run_q;
  assign load_all    = fs_rise & ~run_q & ~init;
  assign reload_tick = fs_rise &  run_q & ~init;
  assign fcnt_inc    = fcnt_q + 1'b1;
endmodule

// File: rtl/tdm_channel.sv
module tdm_channel
  import tdm_pkg::*;
#(
  parameter int unsigned DATA_W = TDM_DATA_W,
  parameter int unsigned POS_W  = TDM_POS_W,
  parameter int unsigned CODE_W = TDM_CODE_W,
  parameter int unsigned CNT_W  = TDM_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  start,
  input  logic [CODE_W-1:0] code,
  input  logic [DATA_W-1:0] hold,
  input  logic              load_all,
  input  logic              reload_tick,
  input  logic [CNT_W-1:0]  fcnt_inc,
  output logic              active,
  output logic              bit_o
);
  localparam int unsigned EXT_W = POS_W + 1;

  logic [EXT_W-1:0]  slot_len, slot_end;
  logic [CNT_W-1:0]  period_mask;
  logic              due, sh_en;
  logic [DATA_W-1:0] shift_q, shift_d;

  assign slot_len    = EXT_W'(DATA_W >> (32'(code) + 32'd1));
  assign slot_end    = {1'b0, start} + slot_len;
  assign period_mask = CNT_W'((32'd2 << code) - 32'd1);
  assign due         = load_all | (reload_tick & ((fcnt_inc & period_mask) == '0));
  assign active      = running && ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < slot_end);
  assign sh_en       = due | active;

  always_comb begin
    if (due) shift_d = hold;
    else     shift_d = {1'b0, shift_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shift_q <= '0;
    else if (sh_en) shift_q <= shift_d;
  end

  assign bit_o = shift_q[0];
endmodule

// File: rtl/tdm_out_select.sv
module tdm_out_select
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH = TDM_NUM_CH
) (
  input  logic [NUM_CH-1:0] active,
  input  logic [NUM_CH-1:0] bits,
  output logic              sdo
);
  always_comb begin
    sdo = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (active[i]) sdo = bits[i];
    end
  end
endmodule

// File: rtl/tdm_serial_mux.sv
module tdm_serial_mux
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH     = TDM_NUM_CH,
  parameter int unsigned DATA_W     = TDM_DATA_W,
  parameter int unsigned POS_W      = TDM_POS_W,
  parameter int unsigned CODE_W     = TDM_CODE_W,
  parameter int unsigned FSZ_W      = TDM_FSZ_W,
  parameter int unsigned FRAME_UNIT = TDM_FRAME_UNIT,
  parameter int unsigned CNT_W      = TDM_CNT_W,
  parameter int unsigned AW         = TDM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_sync,
  output logic              sdo
);
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NUM_CH-1:0][DATA_W-1:0] hold_w;
  logic [NUM_CH-1:0][POS_W-1:0]  start_w;
  logic [NUM_CH-1:0][CODE_W-1:0] code_w;
  logic [FSZ_W-1:0]              fsz_w;
  logic                          init_w;
  logic [POS_W-1:0]              pos_w;
  logic                          running_w, fs_rise_w, load_all_w, reload_tick_w;
  logic [CNT_W-1:0]              fcnt_inc_w;
  logic [NUM_CH-1:0]             active_w, bit_w;

  tdm_host_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .POS_W(POS_W),
    .CODE_W(CODE_W), .FSZ_W(FSZ_W), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hold_o(hold_w), .start_o(start_w), .code_o(code_w),
    .fsz_o(fsz_w), .init_o(init_w)
  );

  tdm_frame_timer #(
    .POS_W(POS_W), .FSZ_W(FSZ_W), .FRAME_UNIT(FRAME_UNIT), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .frame_sync(frame_sync), .init(init_w),
    .fsz(fsz_w), .pos(pos_w), .running(running_w), .fs_rise(fs_rise_w),
    .load_all(load_all_w), .reload_tick(reload_tick_w), .fcnt_inc(fcnt_inc_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tdm_channel #(
      .DATA_W(DATA_W), .POS_W(POS_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_sync_n), .running(running_w), .pos(pos_w),
      .start(start_w[ch]), .code(code_w[ch]), .hold(hold_w[ch]),
      .load_all(load_all_w), .reload_tick(reload_tick_w),
      .fcnt_inc(fcnt_inc_w), .active(active_w[ch]), .bit_o(bit_w[ch])
    );
  end

  tdm_out_select #(.NUM_CH(NUM_CH)) u_sel (
    .active(active_w), .bits(bit_w), .sdo(sdo)
  );
endmodule

// File: rtl/tdm_serial_mux_chk.sv
module tdm_serial_mux_chk #(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned POS_W      = 8,
  parameter int unsigned FSZ_W      = 2,
  parameter int unsigned FRAME_UNIT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              running,
  input logic [POS_W-1:0]  pos,
  input logic [FSZ_W-1:0]  fsz,
  input logic              fs_rise,
  input logic              init,
  input logic [NUM_CH-1:0] active,
  input logic [NUM_CH-1:0] bits
);
  logic [POS_W:0] frame_len;
  assign frame_len = (POS_W+1)'((32'(fsz) + 32'd1) * FRAME_UNIT);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sdo);

  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ({1'b0, pos} < frame_len));

  p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fs_rise && !init && ({1'b0, pos} == frame_len - 1'b1)) |=> (pos == '0));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && !init) |=> (running && pos == '0));

  p_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active[0] |-> (sdo == bits[0]));

  p_gap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active) == 0) |-> !sdo);

  p_reinit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !running);
endmodule

bind tdm_serial_mux tdm_serial_mux_chk #(
  .NUM_CH(NUM_CH), .POS_W(POS_W), .FSZ_W(FSZ_W), .FRAME_UNIT(FRAME_UNIT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sdo(sdo), .running(running_w), .pos(pos_w),
  .fsz(fsz_w), .fs_rise(fs_rise_w), .init(init_w), .active(active_w), .bits(bit_w)
);

// File: tb/tb_tdm_serial_mux.sv
`timescale 1ns/1ps
module tb_tdm_serial_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        frame_sync = 1'b0;
  logic        sdo;

  tdm_serial_mux dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_sync(frame_sync), .sdo(sdo)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_hold[16], m_start[16], m_code[16], m_word[16], m_idx[16];
  int m_fsz, m_pos, m_fcnt;
  bit m_run, m_fs_prev;
  bit m_load[16];

  function automatic bit m_active(int ch);
    int len = 16 >> (m_code[ch] + 1);
    return m_run && (m_pos >= m_start[ch]) && (m_pos < m_start[ch] + len);
  endfunction

  function automatic bit m_sdo();
    for (int ch = 0; ch < 16; ch++)
      if (m_active(ch)) return (m_idx[ch] < 16) ? bit'((m_word[ch] >> m_idx[ch]) & 1) : 1'b0;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 16; ch++) begin
        m_hold[ch] = 0; m_start[ch] = 0; m_code[ch] = 0; m_word[ch] = 0; m_idx[ch] = 16;
      end
      m_fsz = 0; m_pos = 0; m_fcnt = 0; m_run = 0; m_fs_prev = 0;
    end else begin
      bit rise, init;
      rise = frame_sync && !m_fs_prev;
      m_fs_prev = frame_sync;
      init = wr_en && (wr_addr == 5'd26);
      for (int ch = 0; ch < 16; ch++) begin
        if (init)        m_load[ch] = 0;
        else if (!rise)  m_load[ch] = 0;
        else if (!m_run) m_load[ch] = 1;
        else             m_load[ch] = (((m_fcnt + 1) % (2 << m_code[ch])) == 0);
      end
      for (int ch = 0; ch < 16; ch++) begin
        if (m_load[ch]) begin m_word[ch] = m_hold[ch]; m_idx[ch] = 0; end
        else if (m_active(ch)) m_idx[ch] = m_idx[ch] + 1;
      end
      if (init) m_run = 0;
      else if (rise) begin
        m_fcnt = m_run ? (m_fcnt + 1) % 16 : 0;
        m_run = 1;
        m_pos = 0;
      end else if (m_run) begin
        m_pos = (m_pos == 64 * (m_fsz + 1) - 1) ? 0 : m_pos + 1;
      end
      if (wr_en) begin
        if (wr_addr < 16) m_hold[wr_addr] = wr_data;
        else if (wr_addr < 24) begin
          m_start[2*(wr_addr-16)]   = wr_data[7:0];
          m_start[2*(wr_addr-16)+1] = wr_data[15:8];
        end else if (wr_addr < 26) begin
          for (int i = 0; i < 8; i++) m_code[8*(wr_addr-24)+i] = (wr_data >> (2*i)) & 3;
        end else if (wr_addr == 26) m_fsz = wr_data[1:0];
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      bit exp;
      exp = m_sdo();
      checks++;
      if (sdo !== exp) begin
        errors++;
        $display("FAIL %s: sdo=%b expected %b at pos %0d", cur_req, sdo, exp, m_pos);
      end
    end
  end

  // frame sync generator
  int fs_period = 0;
  int fs_cnt = 0;
  always @(negedge clk) begin
    if (fs_period == 0) begin
      frame_sync = 1'b0; fs_cnt = 0;
    end else begin
      frame_sync = (fs_cnt < 2);
      fs_cnt = (fs_cnt + 1) % fs_period;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pat(int ch, int k);
    return ((ch * 16'h1357) ^ (k * 16'h2468) ^ 16'hC3A5) & 16'hFFFF;
  endfunction

  initial begin
    cur_req = "R1 reset";
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    // R7 packing: channels 0..7 at 8*i, channels 8..15 past 64-bit frame (R12)
    cur_req = "R1 R7 before first sync";
    for (int k = 0; k < 4; k++) wr(16 + k, ((16*k + 8) << 8) | (16*k));
    for (int k = 4; k < 8; k++) wr(16 + k, ((200 + 2*k + 1) << 8) | (200 + 2*k));
    for (int ch = 0; ch < 16; ch++) wr(ch, pat(ch, 0));
    wait_cyc(20);
    cur_req = "R4 R6 R9 R12 uniform length";
    fs_period = 64;
    wait_cyc(64 * 6);
    cur_req = "R5 R11 mixed lengths";
    wr(24, 16'hE4E4);
    wr(25, 16'h1B1B);
    for (int f = 0; f < 34; f++) begin
      wait_cyc(37);
      wr(f % 16, pat(f % 16, f + 1));
      wait_cyc(25);
    end
    cur_req = "R8 overlap priority";
    wr(17, (16 << 8) | 16);
    wr(16, (12 << 8) | 0);
    wait_cyc(64 * 10);
    cur_req = "R10 reinit";
    fs_period = 0;
    wait_cyc(3);
    wr(26, 3);
    wait_cyc(30);
    cur_req = "R2 R12 frame 256";
    wr(20, (250 << 8) | 200);
    for (int ch = 0; ch < 16; ch++) wr(ch, pat(ch, 50));
    fs_period = 256;
    wait_cyc(256 * 5);
    cur_req = "R3 early sync";
    fs_period = 0; wait_cyc(2);
    fs_period = 100;
    wait_cyc(100 * 4);
    cur_req = "R2 wrap without sync";
    fs_period = 0; wait_cyc(2);
    wr(26, 1);
    wr(20, (100 << 8) | 60);
    fs_period = 300;
    wait_cyc(300 * 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule